// File: doc/BRIEF.md
# Four-Channel Wiper and Stored-Setting Register Bank

This block holds the tap settings for four digitally controlled resistor channels. Each channel owns one volatile 8-bit wiper register, whose value is driven straight out as the wiper code. Each channel also owns four 8-bit stored-setting registers (slots) that stand in for retained memory. A bus front end, not part of this block, decodes serial traffic and hands over one command per strobe. A command carries an opcode, a channel, a slot and a data byte. The bank executes reads, direct writes, copies between a wiper and a slot for one channel or all four at once, and recall of slot 0 into every wiper at reset.

Any command that changes a slot starts a modelled write cycle. The cycle lasts a parameterised number of clocks, and `busy` is high for all of it. While `busy` is high, every incoming command is dropped. An active-low protect input refuses slot writes, but it still lets the wiper registers be written. Slots keep their contents through reset, so recall at reset restores the last saved setting.

Top module: `pot_reg_bank`

## Requirements
- R1: Opcode 4'b1010 loads `cmd_data` into the wiper of channel `cmd_chan` on the clock after the strobe, and no other channel's wiper changes. Channel c drives `wiper_code[8c+7:8c]`, where 8'h00 is the tap at the low terminal and 8'hFF the tap at the high terminal.
- R2: Opcode 4'b1001 returns the selected channel's wiper on `rd_data`, with `rd_valid` high for exactly the one cycle after the strobe. `rd_valid` is never high without an accepted read.
- R3: Opcode 4'b1100 writes `cmd_data` into slot `cmd_slot` of channel `cmd_chan`, where slot codes 00, 01, 10 and 11 select slots 0 to 3. Opcode 4'b1011 reads a slot back the same way R2 reads a wiper.
- R4: Opcode 4'b1101 copies slot `cmd_slot` of channel `cmd_chan` into that channel's wiper.
- R5: Opcode 4'b1110 copies the wiper of channel `cmd_chan` into slot `cmd_slot` of the same channel.
- R6: Opcode 4'b0001 copies slot `cmd_slot` of every channel into that channel's own wiper, all in the same cycle.
- R7: Opcode 4'b1000 copies every channel's wiper into slot `cmd_slot` of the same channel, all in the same cycle.
- R8: While `rst_n` is low, each wiper is loaded from slot 0 of its own channel, and `busy` and `rd_valid` are cleared. Slot contents are kept through reset.
- R9: An accepted slot-changing command (4'b1100, 4'b1110 or 4'b1000) raises `busy` on the clock after the strobe, and `busy` stays high for exactly WR_CYCLES cycles.
- R10: A command strobed while `busy` is high has no effect: no wiper or slot changes and no read response.
- R11: While `wp_n` is low, slot-changing commands are refused. They change no register and do not raise `busy`. Wiper writes and reads still work.
- R12: Opcodes outside the eight listed above, the step opcode 4'b0010 among them, change nothing, raise no `busy` and produce no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; recalls slot 0 into each wiper |
| cmd_valid | input | 1 | One-cycle command strobe from the bus front end |
| cmd_op | input | 4 | Command opcode |
| cmd_slot | input | 2 | Slot select (0..3) |
| cmd_chan | input | 2 | Channel select (0..3) |
| cmd_data | input | 8 | Data byte for direct writes |
| wp_n | input | 1 | Active-low protect for slot writes |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid, one cycle |
| busy | output | 1 | Modelled retained-memory write cycle in progress |
| wiper_code | output | 32 | Four 8-bit wiper codes, channel 0 in the low byte |

## Verification
A vector table walks each opcode with distinct data per channel and per slot. Because the values differ, a wrong channel decode, a wrong slot decode or a swapped copy direction shows up as a wrong byte, and the extreme codes 8'h00 and 8'hFF appear on two channels. The global copies fill every channel's slot with a different value, so a global copy that touches only the selected channel, or that uses the wrong channel's slot, is told apart from a correct one. Directed tests count the busy cycles clock by clock. They strobe writes, reads and stores inside a busy window, use the protect input on all three slot-changing opcodes while a wiper write is still let through, and overwrite the wipers before a reset so that recall from slot 0 is distinguishable from simple hold.

// File: rtl/pot_pkg.sv
// Package: shared opcode encoding and decoded-command record for the
// wiper/stored-setting register bank.
package pot_pkg;

    typedef enum logic [3:0] {
        OP_RECALL_ALL = 4'b0001,
        OP_STORE_ALL  = 4'b1000,
        OP_RD_WIPER   = 4'b1001,
        OP_WR_WIPER   = 4'b1010,
        OP_RD_SLOT    = 4'b1011,
        OP_WR_SLOT    = 4'b1100,
        OP_RECALL     = 4'b1101,
        OP_STORE      = 4'b1110
    } op_e;

    // One bit per action; at most one is set in any cycle.
    typedef struct packed {
        logic ld_data;     // direct wiper write
        logic recall_one;  // slot -> wiper, one channel
        logic recall_all;  // slot -> wiper, all channels
        logic st_data;     // direct slot write
        logic st_one;      // wiper -> slot, one channel
        logic st_all;      // wiper -> slot, all channels
        logic rd_wiper;    // wiper read
        logic rd_slot;     // slot read
    } act_t;

endpackage

// File: rtl/pot_cmd_decode.sv
// Module: pot_cmd_decode
// Turns one command strobe into a one-hot action record. It drops the
// command while a write cycle is busy, and it masks slot-changing actions
// when protect is active. Assumes cmd_valid is already gated by reset.
module pot_cmd_decode
    import pot_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    input  logic       busy,
    input  logic       wp_n,
    output act_t       act,
    output logic       start_wr
);

    logic accept;
    assign accept = cmd_valid && !busy;

    // Opcode decode into the action record.
    always_comb begin
        act = '0;
        if (accept) begin
            case (op_e'(cmd_op))
                OP_RD_WIPER:   act.rd_wiper   = 1'b1;
                OP_WR_WIPER:   act.ld_data    = 1'b1;
                OP_RD_SLOT:    act.rd_slot    = 1'b1;
                OP_WR_SLOT:    act.st_data    = wp_n;
                OP_RECALL:     act.recall_one = 1'b1;
                OP_STORE:      act.st_one     = wp_n;
                OP_RECALL_ALL: act.recall_all = 1'b1;
                OP_STORE_ALL:  act.st_all     = wp_n;
                default:       act = '0;
            endcase
        end
    end

    // Any slot-changing action opens a write cycle.
    assign start_wr = act.st_data || act.st_one || act.st_all;

endmodule

// File: rtl/pot_wr_timer.sv
// Module: pot_wr_timer
// Models the slow retained-memory write. A start pulse loads WR_CYCLES,
// and busy stays high until the count reaches zero. Assumes start only
// arrives while idle; the decoder guarantees this.
module pot_wr_timer #(
    parameter int WR_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= CNT_W'(WR_CYCLES);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q > CNT_W'(1)) |=> busy);
    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(1) && !start) |=> !busy);
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

endmodule

// File: rtl/pot_channel.sv
// Module: pot_channel
// One channel: a volatile wiper register and SLOTS stored-setting
// registers. The slots have no reset, which models retention, and the
// wiper recalls slot 0 while reset is low. Assumes the action inputs are
// one-hot and already qualified by busy and protect.
module pot_channel #(
    parameter int W     = 8,
    parameter int SLOTS = 4,
    localparam int SL_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              ld_data,
    input  logic              recall_one,
    input  logic              recall_all,
    input  logic              st_data,
    input  logic              st_one,
    input  logic              st_all,
    input  logic [SL_W-1:0]   slot_idx,
    input  logic [W-1:0]      data,
    output logic [W-1:0]      wiper,
    output logic [SLOTS*W-1:0] slots
);

    logic [W-1:0] wiper_q;
    logic [W-1:0] slot_q [SLOTS];
    logic         store_hit;
    logic [W-1:0] store_val;
    logic         recall_hit;

    assign store_hit  = ((st_data || st_one) && sel) || st_all;
    assign store_val  = st_data ? data : wiper_q;
    assign recall_hit = (recall_one && sel) || recall_all;

    // Wiper: recall slot 0 in reset, else direct write or slot copy.
    always_ff @(posedge clk) begin
        if (!rst_n)                wiper_q <= slot_q[0];
        else if (ld_data && sel)   wiper_q <= data;
        else if (recall_hit)       wiper_q <= slot_q[slot_idx];
    end

    // Stored slots: one register each, written when addressed.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (store_hit && slot_idx == SL_W'(s)) slot_q[s] <= store_val;
        end
        assign slots[s*W +: W] = slot_q[s];
    end

    assign wiper = wiper_q;

    assert_reset_recall_R8: assert property (@(posedge clk)
        !rst_n |=> wiper_q == $past(slot_q[0]));
    assert_slot_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_data || st_one || st_all) |=> $stable(slots));
    assert_global_recall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        recall_all |=> wiper_q == $past(slot_q[slot_idx]));
    assert_global_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_all |=> slot_q[$past(slot_idx)] == $past(wiper_q));

endmodule

// File: rtl/pot_reg_bank.sv
// Module: pot_reg_bank (top)
// Four-channel wiper/stored-setting bank. It decodes one command per
// strobe, runs the modelled write-cycle timer, applies protect and
// registers read results. Assumes the front end holds cmd_valid for one
// cycle per command.
module pot_reg_bank
    import pot_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int SLOTS     = 4,
    parameter int W         = 8,
    parameter int WR_CYCLES = 2_500_000,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int SL_W     = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [3:0]          cmd_op,
    input  logic [SL_W-1:0]     cmd_slot,
    input  logic [CH_W-1:0]     cmd_chan,
    input  logic [W-1:0]        cmd_data,
    input  logic                wp_n,
    output logic [W-1:0]        rd_data,
    output logic                rd_valid,
    output logic                busy,
    output logic [NUM_CH*W-1:0] wiper_code
);

    act_t             act;
    logic             start_wr;
    logic             valid_g;
    logic [W-1:0]     wiper_arr [NUM_CH];
    logic [SLOTS*W-1:0] slot_arr [NUM_CH];
    logic [W-1:0]     rd_data_q;
    logic             rd_valid_q;

    assign valid_g = cmd_valid && rst_n;

    pot_cmd_decode u_dec (
        .cmd_valid (valid_g),
        .cmd_op    (cmd_op),
        .busy      (busy),
        .wp_n      (wp_n),
        .act       (act),
        .start_wr  (start_wr)
    );

    pot_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_wr),
        .busy  (busy)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pot_channel #(.W(W), .SLOTS(SLOTS)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (cmd_chan == CH_W'(c)),
            .ld_data    (act.ld_data),
            .recall_one (act.recall_one),
            .recall_all (act.recall_all),
            .st_data    (act.st_data),
            .st_one     (act.st_one),
            .st_all     (act.st_all),
            .slot_idx   (cmd_slot),
            .data       (cmd_data),
            .wiper      (wiper_arr[c]),
            .slots      (slot_arr[c])
        );
        assign wiper_code[c*W +: W] = wiper_arr[c];
    end

    // Read port: capture the addressed wiper or slot for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= act.rd_wiper || act.rd_slot;
            if (act.rd_slot)       rd_data_q <= slot_arr[cmd_chan][cmd_slot*W +: W];
            else if (act.rd_wiper) rd_data_q <= wiper_arr[cmd_chan];
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    assert_wp_refuse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !wp_n &&
         (cmd_op == OP_WR_SLOT || cmd_op == OP_STORE || cmd_op == OP_STORE_ALL))
        |=> !busy);
    assert_rd_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && !busy &&
                           (cmd_op == OP_RD_WIPER || cmd_op == OP_RD_SLOT)));
    assert_drop_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> ($stable(wiper_code) && !rd_valid));
    assert_unknown_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'b0010) |=> ($stable(wiper_code) && !rd_valid));

endmodule

// File: tb/pot_reg_bank_bench.sv
module pot_reg_bank_bench;

    localparam int WRC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_slot = '0;
    logic [1:0]  cmd_chan = '0;
    logic [7:0]  cmd_data = '0;
    logic        wp_n = 1'b1;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        busy;
    logic [31:0] wiper_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pot_reg_bank #(.WR_CYCLES(WRC)) u_pot_reg_bank (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_slot(cmd_slot), .cmd_chan(cmd_chan), .cmd_data(cmd_data),
        .wp_n(wp_n), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .wiper_code(wiper_code)
    );

    // Vector: {op, chan, slot, data, check chan, expected byte}
    localparam int NV = 17;
    localparam logic [25:0] VEC [NV] = '{
        {4'hA, 2'd0, 2'd0, 8'h00, 2'd0, 8'h00},  // R1 low end
        {4'hA, 2'd3, 2'd0, 8'hFF, 2'd3, 8'hFF},  // R1 high end
        {4'h9, 2'd3, 2'd0, 8'h00, 2'd0, 8'hFF},  // R2
        {4'hC, 2'd1, 2'd2, 8'h5A, 2'd0, 8'h00},  // R3 write
        {4'hB, 2'd1, 2'd2, 8'h00, 2'd0, 8'h5A},  // R3 read
        {4'hD, 2'd1, 2'd2, 8'h00, 2'd1, 8'h5A},  // R4
        {4'hE, 2'd3, 2'd1, 8'h00, 2'd3, 8'hFF},  // R5 store
        {4'hB, 2'd3, 2'd1, 8'h00, 2'd0, 8'hFF},  // R5 readback
        {4'hC, 2'd0, 2'd3, 8'h21, 2'd0, 8'h00},  // R6 setup
        {4'hC, 2'd2, 2'd3, 8'h23, 2'd0, 8'h00},
        {4'hC, 2'd3, 2'd3, 8'h24, 2'd0, 8'h00},
        {4'hC, 2'd1, 2'd3, 8'h22, 2'd0, 8'h00},
        {4'h1, 2'd0, 2'd3, 8'h00, 2'd2, 8'h23},  // R6 global recall
        {4'hA, 2'd2, 2'd0, 8'h77, 2'd2, 8'h77},
        {4'h8, 2'd0, 2'd0, 8'h00, 2'd0, 8'h21},  // R7 global store
        {4'hB, 2'd2, 2'd0, 8'h00, 2'd0, 8'h77},  // R7 readback
        {4'hB, 2'd1, 2'd0, 8'h00, 2'd0, 8'h22}   // R7 readback
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wip(input int c);
        return wiper_code[c*8 +: 8];
    endfunction

    // Called at a falling edge; returns one falling edge later.
    task automatic do_cmd(input logic [3:0] op, input logic [1:0] ch,
                          input logic [1:0] sl, input logic [7:0] d);
        cmd_op = op; cmd_chan = ch; cmd_slot = sl; cmd_data = d;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check(busy == 1'b0, "R8", busy, 0);
        check(rd_valid == 1'b0, "R8", rd_valid, 0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] op;
            logic [1:0] xc;
            logic [7:0] xv;
            op = VEC[i][25:22];
            xc = VEC[i][9:8];
            xv = VEC[i][7:0];
            do_cmd(op, VEC[i][21:20], VEC[i][19:18], VEC[i][17:10]);
            if (op == 4'h9 || op == 4'hB) begin
                check(rd_valid == 1'b1, "R2", rd_valid, 1);
                check(rd_data == xv, "R3", rd_data, xv);
            end else begin
                check(wip(xc) == xv, "R1", wip(xc), xv);
            end
            wait_idle();
        end
        // R6/R7: every channel after the global recall and store
        check(wip(0) == 8'h21, "R6", wip(0), 8'h21);
        check(wip(1) == 8'h22, "R6", wip(1), 8'h22);
        check(wip(3) == 8'h24, "R6", wip(3), 8'h24);
        // R2: read response lasts one cycle
        do_cmd(4'h9, 2'd1, 2'd0, 8'h00);
        @(negedge clk);
        check(rd_valid == 1'b0, "R2", rd_valid, 0);

        // R8: overwrite wipers, then reset recalls slot 0 of each channel
        for (int c = 0; c < 4; c++) do_cmd(4'hA, 2'(c), 2'd0, 8'(c + 1));
        check(wip(2) == 8'h03, "R1", wip(2), 8'h03);
        do_reset();
        check(wip(0) == 8'h21, "R8", wip(0), 8'h21);
        check(wip(1) == 8'h22, "R8", wip(1), 8'h22);
        check(wip(2) == 8'h77, "R8", wip(2), 8'h77);
        check(wip(3) == 8'h24, "R8", wip(3), 8'h24);
        do_cmd(4'hB, 2'd1, 2'd2, 8'h00);
        check(rd_data == 8'h5A, "R8", rd_data, 8'h5A);

        // R9: busy length
        begin
            int n;
            n = 0;
            do_cmd(4'hC, 2'd0, 2'd1, 8'h99);
            while (busy && n < 1000) begin n++; @(negedge clk); end
            check(n == WRC, "R9", n, WRC);
        end
        do_cmd(4'hB, 2'd0, 2'd1, 8'h00);
        check(rd_data == 8'h99, "R9", rd_data, 8'h99);

        // R10: commands inside the busy window are dropped
        do_cmd(4'hC, 2'd0, 2'd2, 8'hAB);
        do_cmd(4'hA, 2'd0, 2'd0, 8'hEE);
        check(wip(0) == 8'h21, "R10", wip(0), 8'h21);
        do_cmd(4'h9, 2'd0, 2'd0, 8'h00);
        check(rd_valid == 1'b0, "R10", rd_valid, 0);
        do_cmd(4'hC, 2'd0, 2'd2, 8'h55);
        wait_idle();
        do_cmd(4'hB, 2'd0, 2'd2, 8'h00);
        check(rd_data == 8'hAB, "R10", rd_data, 8'hAB);

        // R11: protect refuses all three slot writers, not wiper writes
        wp_n = 1'b0;
        do_cmd(4'hC, 2'd0, 2'd1, 8'h42);
        check(busy == 1'b0, "R11", busy, 0);
        do_cmd(4'hB, 2'd0, 2'd1, 8'h00);
        check(rd_data == 8'h99, "R11", rd_data, 8'h99);
        do_cmd(4'hE, 2'd3, 2'd1, 8'h00);
        check(busy == 1'b0, "R11", busy, 0);
        do_cmd(4'h8, 2'd0, 2'd1, 8'h00);
        check(busy == 1'b0, "R11", busy, 0);
        do_cmd(4'hB, 2'd3, 2'd1, 8'h00);
        check(rd_data == 8'hFF, "R11", rd_data, 8'hFF);
        do_cmd(4'hB, 2'd0, 2'd1, 8'h00);
        check(rd_data == 8'h99, "R11", rd_data, 8'h99);
        do_cmd(4'hA, 2'd1, 2'd0, 8'h33);
        check(wip(1) == 8'h33, "R11", wip(1), 8'h33);
        wp_n = 1'b1;

        // R12: unlisted opcodes do nothing
        do_cmd(4'h2, 2'd1, 2'd0, 8'h80);
        check(wip(1) == 8'h33, "R12", wip(1), 8'h33);
        check(busy == 1'b0 && rd_valid == 1'b0, "R12", {busy, rd_valid}, 0);
        do_cmd(4'hF, 2'd1, 2'd1, 8'h80);
        do_cmd(4'h0, 2'd1, 2'd1, 8'h80);
        check(wip(1) == 8'h33, "R12", wip(1), 8'h33);
        check(busy == 1'b0 && rd_valid == 1'b0, "R12", {busy, rd_valid}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule